// File: doc/BRIEF.md
# Multigrid V-Cycle Sequencer

This block is the control core of a multigrid solver. It walks one V-cycle over a fixed hierarchy of grid levels, with level 0 the finest. It does no arithmetic. Instead it hands one operation at a time to external numerical units. Each command is a single-cycle strobe that carries an operation code and a level index. The sequencer then holds still until the unit returns a single-cycle completion strobe.

The recursive step list of the V-cycle is unrolled into a descending pass and an ascending pass:

- **Descending pass.** On every level except the coarsest, the sequencer smooths the current estimate a programmable number of times. It then forms the residual, restricts that residual one level down and clears the coarser estimate.
- **Coarsest level.** Here a direct solve stands in for smoothing.
- **Ascending pass.** On the way back up, each level receives the prolongated coarse correction and is then smoothed again the same number of times.

The cycle ends when the last smoothing pass on level 0 completes. A one-cycle done strobe follows, and the sequencer returns to idle.

Top module: `mg_vcycle_seq`

## Requirements
- R1: After reset the block is idle: `cmd_valid_o`, `busy_o` and `done_o` are all low.
- R2: `cmd_valid_o` is high for exactly one cycle per command. No second command is issued until a `cmd_done_i` pulse has been accepted for the first one.
- R3: Descending pass, on each level L below the coarsest, in this order:
  - relax at L, repeated RELAX_ITERS times;
  - residual at L;
  - restrict with level index L;
  - zero with level index L+1.
- R4: On the coarsest level (LEVELS-1), exactly one direct-solve command is issued, and no relax command is issued at that level.
- R5: Ascending pass, for L from LEVELS-2 down to 0: interpolate-and-correct with level index L, then relax at L, repeated RELAX_ITERS times.
- R6: Each smoothing phase (pre and post) on a non-coarsest level issues exactly RELAX_ITERS relax commands.
- R7: `cmd_op_o` encoding: 0 relax, 1 residual, 2 restrict, 3 zero coarse solution, 4 direct solve, 5 interpolate and correct.
- R8: `start_i` has no effect while `busy_o` is high, including the done cycle. `cmd_done_i` has no effect unless a command is outstanding, which excludes idle and the issue cycle itself.
- R9: One cycle after the final completion is accepted, `done_o` is high for exactly one cycle. On the cycle after that, `busy_o` is low.
- R10: With LEVELS = 1, a cycle consists of a single direct-solve command with level index 0.
- R11: A command appears on the cycle after `start_i` is accepted in idle, or on the cycle after the previous command's `cmd_done_i` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a V-cycle when idle |
| cmd_done_i | input | 1 | One-cycle completion of the outstanding command |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 3 | Operation code (R7) |
| cmd_lvl_o | output | LVL_W | Grid level index of the command |
| busy_o | output | 1 | V-cycle in progress |
| done_o | output | 1 | One-cycle end-of-cycle strobe |

## Verification
A corrupted step register or level counter shows up in the very next command strobe, as a wrong opcode or level index. It is caught at that strobe, so the delay is at most one external unit's latency. A faulty smoothing counter shifts every later command by one or more positions. A bad direction flag either turns the ascending pass back into a residual step or ends the cycle early. In both cases the mismatch against the expected command list, or a misplaced done strobe, appears within a few commands. Stray start and completion strobes are injected while busy, in idle and in the issue cycle, so a fault in acceptance timing desynchronises the strobe count at once.

// File: rtl/mg_vcyc_pkg.sv
package mg_vcyc_pkg;

  typedef enum logic [2:0] {
    OP_RELAX    = 3'd0,
    OP_RESID    = 3'd1,
    OP_RESTRICT = 3'd2,
    OP_ZERO     = 3'd3,
    OP_DIRECT   = 3'd4,
    OP_INTERP   = 3'd5
  } mg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_st_e;

endpackage

// File: rtl/mg_level_ctr.sv
module mg_level_ctr #(
  parameter int LEVELS = 3,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             down_i,
  input  logic             up_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             coarsest_o,
  output logic             finest_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LEVELS - 1);

  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             lvl_en;

  always_comb begin
    lvl_en = clr_i | down_i | up_i;
    lvl_d  = lvl_q;
    if (clr_i)       lvl_d = '0;
    else if (down_i) lvl_d = lvl_q + 1'b1;
    else if (up_i)   lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign lvl_o      = lvl_q;
  assign coarsest_o = (lvl_q == LVL_MAX);
  assign finest_o   = (lvl_q == '0);

  // level never leaves the hierarchy (R4, R5)
  assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_MAX);
  assert_no_step_past_coarsest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (down_i && !clr_i) |-> (lvl_q != LVL_MAX));
  assert_no_step_past_finest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && !clr_i && !down_i) |-> (lvl_q != '0));
endmodule

// File: rtl/mg_relax_ctr.sv
module mg_relax_ctr #(
  parameter int RELAX_ITERS = 2,
  localparam int IT_W = (RELAX_ITERS > 1) ? $clog2(RELAX_ITERS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam logic [IT_W-1:0] IT_MAX = IT_W'(RELAX_ITERS - 1);

  logic [IT_W-1:0] it_q, it_d;
  logic            it_en;

  always_comb begin
    it_en = clr_i | inc_i;
    it_d  = clr_i ? '0 : it_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     it_q <= '0;
    else if (it_en) it_q <= it_d;
  end

  assign last_o = (it_q == IT_MAX);

  // smoothing count stays within the programmed repeat count (R6)
  assert_iter_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    it_q <= IT_MAX);
  assert_no_inc_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> !last_o);
endmodule

// File: rtl/mg_vcycle_seq.sv
module mg_vcycle_seq
  import mg_vcyc_pkg::*;
#(
  parameter int LEVELS      = 3,
  parameter int RELAX_ITERS = 2,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmd_done_i,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_op_o,
  output logic [LVL_W-1:0] cmd_lvl_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam bit SINGLE = (LEVELS == 1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LEVELS - 1);

  seq_st_e st_q, st_d;
  mg_op_e  op_q, op_d;
  logic    up_q, up_d;
  logic    step_en;
  logic    lvl_clr, lvl_dn, lvl_up, it_clr, it_inc;
  logic    lvl_coarsest, lvl_finest, it_last;
  logic [LVL_W-1:0] lvl;

  mg_level_ctr #(.LEVELS(LEVELS)) u_level (
    .clk(clk), .rst_n(rst_n), .clr_i(lvl_clr), .down_i(lvl_dn), .up_i(lvl_up),
    .lvl_o(lvl), .coarsest_o(lvl_coarsest), .finest_o(lvl_finest)
  );

  mg_relax_ctr #(.RELAX_ITERS(RELAX_ITERS)) u_relax (
    .clk(clk), .rst_n(rst_n), .clr_i(it_clr), .inc_i(it_inc), .last_o(it_last)
  );

  // next-state and step selection
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    up_d    = up_q;
    step_en = 1'b0;
    lvl_clr = 1'b0;
    lvl_dn  = 1'b0;
    lvl_up  = 1'b0;
    it_clr  = 1'b0;
    it_inc  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_ISSUE;
          step_en = 1'b1;
          op_d    = SINGLE ? OP_DIRECT : OP_RELAX;
          up_d    = 1'b0;
          lvl_clr = 1'b1;
          it_clr  = 1'b1;
        end
      end
      ST_ISSUE: st_d = ST_WAIT;
      ST_WAIT: begin
        if (cmd_done_i) begin
          st_d    = ST_ISSUE;
          step_en = 1'b1;
          unique case (op_q)
            OP_RELAX: begin
              if (!it_last) begin
                it_inc = 1'b1;
              end else if (!up_q) begin
                op_d = OP_RESID;
              end else if (lvl_finest) begin
                st_d = ST_DONE;
              end else begin
                op_d   = OP_INTERP;
                lvl_up = 1'b1;
              end
            end
            OP_RESID:    op_d = OP_RESTRICT;
            OP_RESTRICT: begin
              op_d   = OP_ZERO;
              lvl_dn = 1'b1;
            end
            OP_ZERO: begin
              op_d   = lvl_coarsest ? OP_DIRECT : OP_RELAX;
              it_clr = 1'b1;
            end
            OP_DIRECT: begin
              if (lvl_finest) begin
                st_d = ST_DONE;
              end else begin
                op_d   = OP_INTERP;
                up_d   = 1'b1;
                lvl_up = 1'b1;
              end
            end
            OP_INTERP: begin
              op_d   = OP_RELAX;
              it_clr = 1'b1;
            end
            default: st_d = ST_DONE;
          endcase
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_RELAX;
      up_q <= 1'b0;
    end else if (step_en) begin
      op_q <= op_d;
      up_q <= up_d;
    end
  end

  assign cmd_valid_o = (st_q == ST_ISSUE);
  assign cmd_op_o    = op_q;
  assign cmd_lvl_o   = lvl;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_DONE);

  // command strobe lasts one cycle (R2)
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  // each strobe follows an accepted start or completion (R11)
  assert_strobe_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid_o) |-> ($past(start_i) || $past(cmd_done_i)));
  // zero always targets a coarser level (R3)
  assert_zero_below_finest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 3'd3) |-> (cmd_lvl_o != '0));
  // direct solve only on the coarsest level (R4)
  assert_direct_on_coarsest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_op_o == 3'd4) |-> (cmd_lvl_o == LVL_MAX));
  // opcode stays within the defined set (R7)
  assert_opcode_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_op_o <= 3'd5));
  // start while waiting leaves the command untouched (R8)
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cmd_valid_o && !done_o && start_i && !cmd_done_i)
      |=> ($stable(cmd_op_o) && $stable(cmd_lvl_o) && !cmd_valid_o));
  // done strobe is single and followed by idle (R9)
  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/test_mg_vcycle_seq.sv
module test_mg_vcycle_seq;
  localparam int NLV = 3;
  localparam int NIT = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, cmd_done_i;
  logic cmd_valid_o, busy_o, done_o;
  logic [2:0] cmd_op_o;
  logic [1:0] cmd_lvl_o;

  logic s1, d1, v1, b1, dn1;
  logic [2:0] op1;
  logic [0:0] lv1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mg_vcycle_seq #(.LEVELS(NLV), .RELAX_ITERS(NIT)) i_mg_vcycle_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_done_i(cmd_done_i),
    .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_lvl_o(cmd_lvl_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  mg_vcycle_seq #(.LEVELS(1), .RELAX_ITERS(NIT)) i_mg_vcycle_seq_single (
    .clk(clk), .rst_n(rst_n), .start_i(s1), .cmd_done_i(d1),
    .cmd_valid_o(v1), .cmd_op_o(op1), .cmd_lvl_o(lv1),
    .busy_o(b1), .done_o(dn1)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // expected command list (R3, R4, R5, R6, R7: 0 relax 1 resid 2 restrict 3 zero 4 direct 5 interp)
  int exp_op[64];
  int exp_lvl[64];
  int exp_len;
  initial begin
    exp_len = 0;
    for (int l = 0; l < NLV - 1; l++) begin
      for (int k = 0; k < NIT; k++) begin exp_op[exp_len] = 0; exp_lvl[exp_len] = l; exp_len++; end
      exp_op[exp_len] = 1; exp_lvl[exp_len] = l;     exp_len++;
      exp_op[exp_len] = 2; exp_lvl[exp_len] = l;     exp_len++;
      exp_op[exp_len] = 3; exp_lvl[exp_len] = l + 1; exp_len++;
    end
    exp_op[exp_len] = 4; exp_lvl[exp_len] = NLV - 1; exp_len++;
    for (int l = NLV - 2; l >= 0; l--) begin
      exp_op[exp_len] = 5; exp_lvl[exp_len] = l; exp_len++;
      for (int k = 0; k < NIT; k++) begin exp_op[exp_len] = 0; exp_lvl[exp_len] = l; exp_len++; end
    end
  end

  // cycle reference model: expected strobes and busy after each edge
  bit m_busy, m_out, m_fin, e_valid, e_done;
  int m_cnt;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_out = 0; m_fin = 0; e_valid = 0; e_done = 0; m_cnt = 0;
    end else begin
      bit was_valid;
      was_valid = e_valid;
      e_valid = 0;
      e_done  = 0;
      if (m_fin) begin
        m_fin = 0; m_busy = 0;
      end else if (!m_busy) begin
        if (start_i) begin m_busy = 1; e_valid = 1; m_cnt = 0; end
      end else if (was_valid) begin
        m_out = 1;
      end else if (m_out && cmd_done_i) begin
        m_out = 0;
        m_cnt++;
        if (m_cnt == exp_len) begin m_fin = 1; e_done = 1; end
        else e_valid = 1;
      end
    end
  end

  // per-cycle compare and command responder
  bit inj_issue, idle_poke;
  int dly_base;
  int rsp_idx, wait_cnt;
  always @(negedge clk) begin
    if (rst_n) begin
      cmd_done_i = 0;
      chk(cmd_valid_o == e_valid, "R2/R11 strobe timing", cmd_valid_o, e_valid);
      chk(done_o == e_done, "R9 done strobe", done_o, e_done);
      chk(busy_o == m_busy, "R8/R9 busy", busy_o, m_busy);
      if (cmd_valid_o) begin
        chk(rsp_idx < exp_len, "R3 command count", rsp_idx, exp_len);
        if (rsp_idx < exp_len) begin
          chk(int'(cmd_op_o) == exp_op[rsp_idx], "R3/R4/R5/R7 opcode", cmd_op_o, exp_op[rsp_idx]);
          chk(int'(cmd_lvl_o) == exp_lvl[rsp_idx], "R3/R4/R5/R6 level", cmd_lvl_o, exp_lvl[rsp_idx]);
        end
        rsp_idx++;
        wait_cnt = inj_issue ? 2 + (rsp_idx % 3) : dly_base + (rsp_idx % 4);
        if (inj_issue) cmd_done_i = 1;   // stray completion in the issue cycle (R8)
      end else if (wait_cnt > 0) begin
        wait_cnt--;
        if (wait_cnt == 0) cmd_done_i = 1;
      end else if (idle_poke && !busy_o) begin
        cmd_done_i = 1;                  // stray completion while idle (R8)
        idle_poke = 0;
      end
    end
  end

  task automatic run_cycle(input bit inj, input int dly, input bit busy_start, input bit done_start);
    inj_issue = inj;
    dly_base  = dly;
    rsp_idx   = 0;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    if (busy_start) begin
      repeat (6) @(negedge clk);
      start_i = 1;
      @(negedge clk) start_i = 0;
    end
    while (!done_o) @(negedge clk);
    if (done_start) start_i = 1;         // start in the done cycle (R8)
    @(negedge clk) start_i = 0;
    chk(rsp_idx == exp_len, "R3/R5/R6 total commands", rsp_idx, exp_len);
    repeat (4) @(negedge clk);
    chk(busy_o == 0 && cmd_valid_o == 0, "R8 no restart", busy_o, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; cmd_done_i = 0; s1 = 0; d1 = 0;
    inj_issue = 0; idle_poke = 0; dly_base = 1; rsp_idx = 0; wait_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_valid_o == 0, "R1 valid after reset", cmd_valid_o, 0);
    chk(busy_o == 0, "R1 busy after reset", busy_o, 0);
    chk(done_o == 0, "R1 done after reset", done_o, 0);
    idle_poke = 1;
    repeat (4) @(negedge clk);
    chk(cmd_valid_o == 0 && busy_o == 0, "R8 idle completion ignored", busy_o, 0);

    run_cycle(0, 1, 1, 0);
    run_cycle(1, 2, 0, 1);
    run_cycle(0, 3, 1, 1);

    // single-level hierarchy (R10)
    @(negedge clk) s1 = 1;
    @(negedge clk) s1 = 0;
    chk(v1 == 1, "R10 strobe", v1, 1);
    chk(op1 == 3'd4, "R10 direct opcode", op1, 4);
    chk(lv1 == 1'b0, "R10 level", lv1, 0);
    @(negedge clk);
    chk(v1 == 0, "R10 single strobe", v1, 0);
    d1 = 1;
    @(negedge clk) d1 = 0;
    chk(dn1 == 1, "R10 done after direct", dn1, 1);
    @(negedge clk);
    chk(b1 == 0 && dn1 == 0, "R10 back to idle", b1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule